// File: doc/BRIEF.md
# Stop Mode Wake-Up Controller

This block sequences a deep-sleep stop mode in which the main oscillator is switched off. A stop request from the processor parks the block in a stopped state with the oscillator and the processor clock disabled. Two events end the stop: an external reset input, or an interrupt request from any source whose 3-bit priority level is not the masked code. Either wake turns the oscillator back on at once. The block then holds the processor clock off until a stabilization wait has run out.

The two wake paths share one stabilization counter but end differently. On a reset wake, reset is held to the processor for the whole wait, which uses a fixed wait code. When the wait ends, a single-cycle pulse starts the reset sequence. On an interrupt wake, the wait length comes from a 2-bit select sampled when the wake is detected. When that wait ends, a single-cycle resume pulse restarts the processor at the instruction after its stop request. Whether the interrupt is then taken is decided outside this block.

The block runs on an always-on clock. Wait counts are 2^10, 2^13, 2^15 and 2^17 cycles, scaled down by a shift parameter.

Top module: `stopwake_ctrl`

## Requirements
- R1: After the synchronous reset `sys_rst`, the block is running: `osc_en` and `cpu_clk_en` are 1, and `cpu_rst_hold`, `rst_seq_start` and `int_resume` are 0.
- R2: A `stop_req` sampled while running takes the block to the stopped state. From the next cycle, `osc_en` and `cpu_clk_en` are 0 while no wake is present.
- R3: In the stopped state, only `ext_reset_req` or a qualifying interrupt leaves the stop. Repeated `stop_req`, unmasked levels with no request, and masked requests keep all outputs as in R2.
- R4: Source i qualifies when `irq_req[i]` is 1 and its level `irq_level[3*i+2:3*i]` is not 3'b111. The value 3'b111 masks the source.
- R5: `osc_en` returns to 1 in the same cycle a wake is present in the stopped state.
- R6: If `ext_reset_req` and a qualifying interrupt are present together in the stopped state, the reset path is taken.
- R7: An interrupt wake is followed by 2^(E-WAIT_SHIFT) wait cycles, with E = 10, 13, 15, 17 for `wait_sel` = 0, 1, 2, 3 sampled in the wake cycle. `int_resume` is 1 in the last wait cycle only. The block is running on the cycle after.
- R8: A reset wake is followed by a wait of the length given in R7 for code `RST_WAIT_CODE`. `cpu_rst_hold` is 1 in every wait cycle and `rst_seq_start` is 1 in the last one only. Then comes one reset-sequence cycle with `cpu_clk_en` 1 and `cpu_rst_hold` 0, and the block is then running.
- R9: `cpu_clk_en` is 0 in the stopped state and in every wait cycle of either path.
- R10: `ext_reset_req` during an interrupt wait, including its last cycle, suppresses `int_resume` and starts a full reset wait per R8 from the next cycle.
- R11: Changes of `wait_sel` after the wake cycle do not change the length of the wait in progress.
- R12: `stop_req` is ignored in every state other than running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| sys_rst | input | 1 | Synchronous active-high reset of the block |
| stop_req | input | 1 | Processor request to enter stop |
| ext_reset_req | input | 1 | External reset input, wake source with priority |
| irq_req | input | N_SRC | Per-source interrupt requests |
| irq_level | input | 3*N_SRC | Per-source 3-bit levels, 3'b111 masks |
| wait_sel | input | 2 | Stabilization wait select for interrupt wakes |
| osc_en | output | 1 | Main oscillator enable |
| cpu_clk_en | output | 1 | Processor clock gate enable |
| cpu_rst_hold | output | 1 | Reset held to the processor during a reset wait |
| rst_seq_start | output | 1 | One-cycle pulse starting the reset sequence |
| int_resume | output | 1 | One-cycle pulse resuming the processor after an interrupt wake |

## Verification
A wrong state is visible at the ports in the cycle it occurs, because every output is decoded from the state. Examples are a stop taken outside the running state, a wake that is missed, or the wrong path being entered. These show at once as a wrong `osc_en`, `cpu_clk_en` or `cpu_rst_hold`. A wrong wait length or a wrong captured select appears only at the end of the wait, as an early or late pulse. The bench model is therefore compared on every cycle of every wait, for all four select codes, with the select changed partway through a wait and a reset arriving during an interrupt wait.

// File: rtl/stopwake_pkg.sv
package stopwake_pkg;

    localparam int LVL_W = 3;
    localparam logic [LVL_W-1:0] LVL_MASKED = 3'b111;
    localparam int MAX_EXP = 17;

    typedef enum logic [2:0] {
        SW_RUN,
        SW_STOP,
        SW_WAIT_RST,
        SW_WAIT_INT,
        SW_RST_SEQ
    } sw_state_e;

    typedef struct packed {
        logic rst;
        logic irq;
    } wake_req_t;

    // exponent of the stabilization count for each select code
    function automatic int unsigned stab_exp(input logic [1:0] code);
        case (code)
            2'd0:    return 10;
            2'd1:    return 13;
            2'd2:    return 15;
            default: return 17;
        endcase
    endfunction

endpackage

// File: rtl/sw_wake_qual.sv
module sw_wake_qual
    import stopwake_pkg::*;
#(
    parameter int N_SRC = 4
) (
    input  logic                   ext_reset_req,
    input  logic [N_SRC-1:0]       irq_req,
    input  logic [N_SRC*LVL_W-1:0] irq_level,
    output wake_req_t              wake
);
    logic [N_SRC-1:0] hit;

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        assign hit[i] = irq_req[i] && (irq_level[i*LVL_W +: LVL_W] != LVL_MASKED);
    end

    always_comb begin
        wake.rst = ext_reset_req;
        wake.irq = |hit;
    end
endmodule

// File: rtl/sw_stab_timer.sv
module sw_stab_timer
    import stopwake_pkg::*;
#(
    parameter int WAIT_SHIFT = 0   // keep at most 9 so every wait is at least 2 cycles
) (
    input  logic       clk,
    input  logic       sys_rst,
    input  logic       load,
    input  logic [1:0] load_code,
    input  logic       run,
    output logic       tc
);
    localparam int CNT_W = MAX_EXP - WAIT_SHIFT + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_q;

    always_ff @(posedge clk) begin
        if (sys_rst) begin
            cnt_q  <= '0;
            last_q <= '0;
        end else if (load) begin
            cnt_q  <= '0;
            last_q <= CNT_W'((32'd1 << (stab_exp(load_code) - WAIT_SHIFT)) - 32'd1);
        end else if (run && !tc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tc = run && (cnt_q == last_q);

    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (sys_rst)
        run |-> (cnt_q <= last_q));
    p_tc_single_r7: assert property (@(posedge clk) disable iff (sys_rst)
        tc |=> !tc);
    p_load_restart_r11: assert property (@(posedge clk) disable iff (sys_rst)
        load |=> !tc);
endmodule

// File: rtl/sw_fsm.sv
module sw_fsm
    import stopwake_pkg::*;
#(
    parameter logic [1:0] RST_WAIT_CODE = 2'd3
) (
    input  logic       clk,
    input  logic       sys_rst,
    input  logic       stop_req,
    input  logic       ext_reset_req,
    input  wake_req_t  wake,
    input  logic [1:0] wait_sel,
    input  logic       tc,
    output logic       load,
    output logic [1:0] load_code,
    output logic       run,
    output logic       osc_en,
    output logic       cpu_clk_en,
    output logic       cpu_rst_hold,
    output logic       rst_seq_start,
    output logic       int_resume
);
    sw_state_e state_q, state_d;

    always_comb begin
        state_d   = state_q;
        load      = 1'b0;
        load_code = wait_sel;
        unique case (state_q)
            SW_RUN: if (stop_req) state_d = SW_STOP;
            SW_STOP: begin
                if (wake.rst) begin
                    state_d   = SW_WAIT_RST;
                    load      = 1'b1;
                    load_code = RST_WAIT_CODE;
                end else if (wake.irq) begin
                    state_d = SW_WAIT_INT;
                    load    = 1'b1;
                end
            end
            SW_WAIT_INT: begin
                if (ext_reset_req) begin
                    state_d   = SW_WAIT_RST;
                    load      = 1'b1;
                    load_code = RST_WAIT_CODE;
                end else if (tc) begin
                    state_d = SW_RUN;
                end
            end
            SW_WAIT_RST: if (tc) state_d = SW_RST_SEQ;
            SW_RST_SEQ:  state_d = SW_RUN;
            default:     state_d = SW_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (sys_rst) state_q <= SW_RUN;
        else         state_q <= state_d;
    end

    assign run           = (state_q == SW_WAIT_RST) || (state_q == SW_WAIT_INT);
    assign osc_en        = (state_q != SW_STOP) || wake.rst || wake.irq;
    assign cpu_clk_en    = (state_q == SW_RUN) || (state_q == SW_RST_SEQ);
    assign cpu_rst_hold  = (state_q == SW_WAIT_RST);
    assign rst_seq_start = (state_q == SW_WAIT_RST) && tc;
    assign int_resume    = (state_q == SW_WAIT_INT) && tc && !ext_reset_req;

    p_stop_gates_r2: assert property (@(posedge clk) disable iff (sys_rst)
        (state_q == SW_RUN && stop_req) |=> !cpu_clk_en);
    p_stay_stopped_r3: assert property (@(posedge clk) disable iff (sys_rst)
        (state_q == SW_STOP && !wake.rst && !wake.irq) |=> (state_q == SW_STOP));
    p_rst_priority_r6: assert property (@(posedge clk) disable iff (sys_rst)
        (state_q == SW_STOP && wake.rst) |=> (state_q == SW_WAIT_RST));
    p_resume_runs_r7: assert property (@(posedge clk) disable iff (sys_rst)
        int_resume |=> (state_q == SW_RUN));
    p_rstseq_after_r8: assert property (@(posedge clk) disable iff (sys_rst)
        rst_seq_start |=> (cpu_clk_en && !cpu_rst_hold));
    p_clk_needs_osc_r9: assert property (@(posedge clk) disable iff (sys_rst)
        !osc_en |-> !cpu_clk_en);
    p_pulse_excl_r10: assert property (@(posedge clk) disable iff (sys_rst)
        !(int_resume && rst_seq_start));
endmodule

// File: rtl/stopwake_ctrl.sv
module stopwake_ctrl
    import stopwake_pkg::*;
#(
    parameter int         N_SRC         = 4,
    parameter int         WAIT_SHIFT    = 0,
    parameter logic [1:0] RST_WAIT_CODE = 2'd3
) (
    input  logic                   clk,
    input  logic                   sys_rst,
    input  logic                   stop_req,
    input  logic                   ext_reset_req,
    input  logic [N_SRC-1:0]       irq_req,
    input  logic [N_SRC*LVL_W-1:0] irq_level,
    input  logic [1:0]             wait_sel,
    output logic                   osc_en,
    output logic                   cpu_clk_en,
    output logic                   cpu_rst_hold,
    output logic                   rst_seq_start,
    output logic                   int_resume
);
    wake_req_t  wake;
    logic       load;
    logic [1:0] load_code;
    logic       run;
    logic       tc;

    sw_wake_qual #(.N_SRC(N_SRC)) u_qual (
        .ext_reset_req (ext_reset_req),
        .irq_req       (irq_req),
        .irq_level     (irq_level),
        .wake          (wake)
    );

    sw_stab_timer #(.WAIT_SHIFT(WAIT_SHIFT)) u_timer (
        .clk       (clk),
        .sys_rst   (sys_rst),
        .load      (load),
        .load_code (load_code),
        .run       (run),
        .tc        (tc)
    );

    sw_fsm #(.RST_WAIT_CODE(RST_WAIT_CODE)) u_fsm (
        .clk           (clk),
        .sys_rst       (sys_rst),
        .stop_req      (stop_req),
        .ext_reset_req (ext_reset_req),
        .wake          (wake),
        .wait_sel      (wait_sel),
        .tc            (tc),
        .load          (load),
        .load_code     (load_code),
        .run           (run),
        .osc_en        (osc_en),
        .cpu_clk_en    (cpu_clk_en),
        .cpu_rst_hold  (cpu_rst_hold),
        .rst_seq_start (rst_seq_start),
        .int_resume    (int_resume)
    );
endmodule

// File: tb/stopwake_ctrl_tb.sv
module stopwake_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N = 4;
    localparam int SHIFT = 7;

    logic clk = 1'b0;
    logic sys_rst = 1'b1;
    logic stop_req = 1'b0;
    logic ext_reset_req = 1'b0;
    logic [N-1:0] irq_req = '0;
    logic [N*3-1:0] irq_level = '0;
    logic [1:0] wait_sel = 2'd0;
    logic osc_en, cpu_clk_en, cpu_rst_hold, rst_seq_start, int_resume;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 0;
    string cur_req = "R1";

    // reference model: 0 run, 1 stopped, 2 reset wait, 3 interrupt wait, 4 reset sequence
    int m_mode = 0;
    int m_left = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stopwake_ctrl #(.N_SRC(N), .WAIT_SHIFT(SHIFT), .RST_WAIT_CODE(2'd3)) u_dut (
        .clk(clk), .sys_rst(sys_rst), .stop_req(stop_req), .ext_reset_req(ext_reset_req),
        .irq_req(irq_req), .irq_level(irq_level), .wait_sel(wait_sel),
        .osc_en(osc_en), .cpu_clk_en(cpu_clk_en), .cpu_rst_hold(cpu_rst_hold),
        .rst_seq_start(rst_seq_start), .int_resume(int_resume));

    function automatic int wait_len(input int code);
        int e;
        if (code == 0) e = 10;
        else if (code == 1) e = 13;
        else if (code == 2) e = 15;
        else e = 17;
        return 1 << (e - SHIFT);
    endfunction

    function automatic bit any_wake_irq();
        bit w = 0;
        for (int i = 0; i < N; i++)
            if (irq_req[i] && irq_level[3*i +: 3] != 3'b111) w = 1;
        return w;
    endfunction

    task automatic chk(input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %0b expected %0b (cycle %0d)", cur_req, what, act, exp, cycles);
        end
    endtask

    task automatic compare();
        bit wi = any_wake_irq();
        chk("osc_en", osc_en, (m_mode != 1) || ext_reset_req || wi);
        chk("cpu_clk_en", cpu_clk_en, (m_mode == 0) || (m_mode == 4));
        chk("cpu_rst_hold", cpu_rst_hold, m_mode == 2);
        chk("rst_seq_start", rst_seq_start, (m_mode == 2) && (m_left == 1));
        chk("int_resume", int_resume, (m_mode == 3) && (m_left == 1) && !ext_reset_req);
    endtask

    task automatic model_step();
        bit wi = any_wake_irq();
        case (m_mode)
            0: if (stop_req) m_mode = 1;
            1: if (ext_reset_req) begin m_mode = 2; m_left = wait_len(3); end
               else if (wi) begin m_mode = 3; m_left = wait_len(wait_sel); end
            3: if (ext_reset_req) begin m_mode = 2; m_left = wait_len(3); end
               else if (m_left == 1) m_mode = 0;
               else m_left--;
            2: if (m_left == 1) m_mode = 4; else m_left--;
            default: m_mode = 0;
        endcase
    endtask

    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) begin
            #1;
            compare();
            model_step();
            @(negedge clk);
        end
    endtask

    function automatic logic [N*3-1:0] levels(input int a, input int b, input int c, input int d);
        return {d[2:0], c[2:0], b[2:0], a[2:0]};
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        sys_rst = 1'b0;
        m_mode = 0;
        // R1: reset state
        cur_req = "R1";
        #1;
        chk("osc_en", osc_en, 1'b1);
        chk("cpu_clk_en", cpu_clk_en, 1'b1);
        chk("cpu_rst_hold", cpu_rst_hold, 1'b0);
        chk("rst_seq_start", rst_seq_start, 1'b0);
        chk("int_resume", int_resume, 1'b0);
        cyc(3);

        // R2: enter stop
        cur_req = "R2";
        stop_req = 1; cyc(1); stop_req = 0; cyc(4);
        // R3, R4: masked requests and unrequested levels do not wake; R12 stop ignored
        cur_req = "R3/R4 masked";
        irq_level = levels(7, 7, 2, 7); irq_req = 4'b1011; cyc(4);
        irq_req = 4'b0000; irq_level = levels(0, 1, 2, 3); cyc(3);
        cur_req = "R12 stop in stop";
        stop_req = 1; cyc(2); stop_req = 0;
        // R5, R7, R11: wake by source 2, select 0, change select mid-wait
        cur_req = "R5/R7 sel0";
        wait_sel = 2'd0; irq_req = 4'b0100; cyc(1); irq_req = 0;
        cur_req = "R11 sel change";
        wait_sel = 2'd3; cyc(3);
        cur_req = "R12 stop in wait";
        stop_req = 1; cyc(1); stop_req = 0;
        cur_req = "R7 sel0 end";
        cyc(8);

        // R7 select 1
        cur_req = "R7 sel1";
        stop_req = 1; cyc(1); stop_req = 0; cyc(2);
        wait_sel = 2'd1; irq_level = levels(0, 0, 0, 6); irq_req = 4'b1000; cyc(1);
        irq_req = 0; wait_sel = 2'd0; cyc(70);

        // R6, R8, R9: reset and interrupt together
        cur_req = "R6/R8 reset wake";
        stop_req = 1; cyc(1); stop_req = 0; cyc(2);
        ext_reset_req = 1; irq_req = 4'b0001; cyc(1);
        ext_reset_req = 0; irq_req = 0; cyc(1030);

        // R10: reset during interrupt wait
        cur_req = "R10 reset in int wait";
        stop_req = 1; cyc(1); stop_req = 0; cyc(2);
        wait_sel = 2'd2; irq_req = 4'b0010; cyc(1); irq_req = 0; cyc(20);
        ext_reset_req = 1; cyc(1); ext_reset_req = 0; cyc(1030);

        // R10: reset in last interrupt wait cycle, select 0 (8 cycles)
        cur_req = "R10 reset at end";
        stop_req = 1; cyc(1); stop_req = 0; cyc(1);
        wait_sel = 2'd0; irq_req = 4'b0001; cyc(1); irq_req = 0; cyc(7);
        ext_reset_req = 1; cyc(1); ext_reset_req = 0; cyc(1030);

        // R7 select 2 and 3
        cur_req = "R7 sel2";
        stop_req = 1; cyc(1); stop_req = 0;
        wait_sel = 2'd2; irq_req = 4'b0100; cyc(1); irq_req = 0; cyc(260);
        cur_req = "R7 sel3";
        stop_req = 1; cyc(1); stop_req = 0; cyc(1);
        wait_sel = 2'd3; irq_req = 4'b1000; cyc(1); irq_req = 0; cyc(1030);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule